// File: doc/BRIEF.md
# Bang-bang clock/data phase detector

This block is the decision stage of a digital clock-recovery or frequency-synthesis loop. It samples a serial input on both edges of the local clock. The sample taken on the rising edge is the retimed data bit. The sample taken on the falling edge lands near the point where the data changes. When the loop is in lock, data transitions sit on the falling clock edge and the rising edge samples each bit at its centre, half a bit period away. In that ideal case the detector tolerates up to 1 UI peak-to-peak of input jitter. Real setup and hold margins reduce this to about 0.8 UI.

For each 0-to-1 transition of the data, the detector reports a single bit: did the transition arrive before or after the falling clock edge between the two rising-edge samples around it. It gives no magnitude. The report comes with a one-cycle valid strobe, so a downstream integrator or charge-pump model can count early and late events. Between reports the direction output holds its last value, because the loop keeps steering the clock phase the same way until the next qualifying transition.

Each sampling path passes through a synchronizer of `SYNC_STAGES` flops clocked on its own edge. The falling-edge path is then moved into the rising-edge domain, and all decisions are made there.

Top module: `bb_phase_det`

## Requirements
- R1: While `rst_n` is low, `rdata_o`, `dir_o` and `valid_o` are all 0.
- R2: `rdata_o` follows the rising-edge sample of `din`. A level that `din` takes up within the clock cycle that starts at rising edge k appears on `rdata_o` just after rising edge k+`SYNC_STAGES` (k+2 by default).
- R3: For each 0-to-1 transition of `din` in the cycle that starts at rising edge k, `valid_o` is 1 for exactly the one cycle that follows rising edge k+`SYNC_STAGES`+1. At no other time is it 1 for that transition.
- R4: Direction encoding. On the strobe, `dir_o` is 1 when the transition came before the falling clock edge of that cycle (early). It is 0 when the transition came after that falling edge and before the next rising edge (late).
- R5: `dir_o` changes only in a cycle where `valid_o` is 1. A 1-to-0 transition of `din`, or steady data, leaves `dir_o` unchanged and `valid_o` at 0.
- R6: `valid_o` is never 1 in two consecutive cycles.
- R7: Rising transitions that are only two bits apart (pattern 0,1,0,1) each get their own strobe, two cycles apart, and each strobe carries that transition's direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local recovered or synthesized clock; both edges sample `din` |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Serial data input |
| rdata_o | output | 1 | Retimed data bit (rising-edge sample) |
| dir_o | output | 1 | Held direction: 1 = early, 0 = late (R4) |
| valid_o | output | 1 | One-cycle strobe marking a fresh direction decision |

## Verification
The bench places a rising data transition at a series of offsets across the whole clock period, on both sides of the falling edge. For each one it checks that the direction matches the sign of the offset, and that the strobe and retimed bit arrive at the exact edges given above. If the falling-edge path were misaligned by one cycle relative to the rising path, the decision near the edge would flip or the strobe would land a cycle early or late. A falling data edge placed on the opposite side of the clock edge must leave the held direction alone. A design that also updated on 1-to-0 transitions would flip `dir_o` there. Back-to-back rises check that a comparison with a stale previous bit does not swallow the second strobe.

// File: rtl/pd_pkg.sv
package pd_pkg;

  // One decision produced by the detector
  typedef struct packed {
    logic valid;
    logic dir;
  } pd_event_t;

  // A qualifying event is a 0-to-1 step between consecutive rising samples
  function automatic logic pd_is_rise(input logic prev_bit, input logic cur_bit);
    return (~prev_bit) & cur_bit;
  endfunction

  // The mid-bit (falling-edge) sample already equals the new bit when the
  // transition happened before the falling edge, i.e. the data was early.
  function automatic logic pd_is_early(input logic mid_bit, input logic cur_bit);
    return (mid_bit == cur_bit);
  endfunction

endpackage

// File: rtl/pd_sync_chain.sv
module pd_sync_chain #(
  parameter int STAGES   = 2,
  parameter bit NEG_EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] stg;

  generate
    if (NEG_EDGE) begin : g_neg
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
      end
    end else begin : g_pos
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg[LAST];
endmodule

// File: rtl/pd_decide.sv
module pd_decide
  import pd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rise_samp,   // rising-edge sample, current bit
  input  logic fall_samp,   // falling-edge sample, still in falling domain
  output logic rise_evt,
  output logic early_evt,
  output pd_event_t evt_q
);
  logic prev_q;   // previous rising-edge sample
  logic mid_q;    // falling sample taken between prev_q and rise_samp

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      mid_q  <= 1'b0;
    end else begin
      prev_q <= rise_samp;
      mid_q  <= fall_samp;
    end
  end

  assign rise_evt  = pd_is_rise(prev_q, rise_samp);
  assign early_evt = pd_is_early(mid_q, rise_samp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
    end else begin
      evt_q.valid <= rise_evt;
      if (rise_evt) evt_q.dir <= early_evt;
    end
  end
endmodule

// File: rtl/bb_phase_det.sv
module bb_phase_det
  import pd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rdata_o,
  output logic dir_o,
  output logic valid_o
);
  logic      rise_samp;
  logic      fall_samp;
  logic      rise_evt;
  logic      early_evt;
  pd_event_t evt_q;

  pd_sync_chain #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b0)) u_rise_sync (
    .clk(clk), .rst_n(rst_n), .d(din), .q(rise_samp)
  );

  pd_sync_chain #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b1)) u_fall_sync (
    .clk(clk), .rst_n(rst_n), .d(din), .q(fall_samp)
  );

  pd_decide u_decide (
    .clk(clk), .rst_n(rst_n),
    .rise_samp(rise_samp), .fall_samp(fall_samp),
    .rise_evt(rise_evt), .early_evt(early_evt),
    .evt_q(evt_q)
  );

  assign rdata_o = rise_samp;
  assign dir_o   = evt_q.dir;
  assign valid_o = evt_q.valid;
endmodule

// File: rtl/pd_checker.sv
module pd_checker (
  input logic clk,
  input logic rst_n,
  input logic rdata_o,
  input logic dir_o,
  input logic valid_o,
  input logic rise_evt,
  input logic early_evt
);
  // R1: outputs cleared while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (rdata_o == 1'b0 && dir_o == 1'b0 && valid_o == 1'b0);
    end
  end

  // R3: strobe exactly when the retimed bit stepped from 0 to 1 one cycle earlier
  a_r3_strobe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o == ($past(rdata_o) && !$past(rdata_o, 2)));

  // R4: the decision carried by the strobe is the one formed at the rise
  a_r4_dir_from_event: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> (valid_o && dir_o == $past(early_evt)));

  // R5: direction holds whenever no strobe is present
  a_r5_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(dir_o));

  // R6: strobe never lasts two cycles
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R2: retimed output never unknown out of reset
  a_r2_known: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({rdata_o, dir_o, valid_o}));
endmodule

bind bb_phase_det pd_checker u_pd_checker (
  .clk(clk), .rst_n(rst_n),
  .rdata_o(rdata_o), .dir_o(dir_o), .valid_o(valid_o),
  .rise_evt(rise_evt), .early_evt(early_evt)
);

// File: tb/tb_bb_phase_det.sv
`timescale 1ns/1ps
module tb_bb_phase_det;
  localparam realtime TCK = 5.0;   // 200 MHz
  localparam realtime TFALL = TCK / 2.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic rdata_o, dir_o, valid_o;

  int n_checks = 0;
  int n_errors = 0;
  logic held_dir;

  bb_phase_det #(.SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .din(din),
    .rdata_o(rdata_o), .dir_o(dir_o), .valid_o(valid_o)
  );

  always #(TCK / 2.0) clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive din to val at an offset after the next rising edge (edge k)
  task automatic drive_at(input realtime off, input logic val);
    @(posedge clk);
    #(off);
    din = val;
  endtask

  // Rising transition at offset off; verify timing, data and direction
  task automatic rise_trial(input realtime off);
    logic exp_dir;
    exp_dir = (off < TFALL);          // R4: before falling edge -> early (1)
    drive_at(off, 1'b0);
    repeat (4) @(posedge clk);
    drive_at(off, 1'b1);              // edge k
    @(posedge clk); #1;               // after k+1
    check("R2 rdata not yet", rdata_o, 1'b0);
    check("R3 no early strobe", valid_o, 1'b0);
    @(posedge clk); #1;               // after k+2
    check("R2 rdata updated", rdata_o, 1'b1);
    check("R3 no early strobe", valid_o, 1'b0);
    @(posedge clk); #1;               // after k+3
    check("R3 strobe", valid_o, 1'b1);
    check("R4 direction", dir_o, exp_dir);
    held_dir = exp_dir;
    @(posedge clk); #1;               // after k+4
    check("R6 strobe ends", valid_o, 1'b0);
    check("R5 dir held", dir_o, held_dir);
  endtask

  // Falling transition on the opposite side of the falling edge: no effect
  task automatic fall_trial(input realtime off);
    drive_at(off, 1'b0);
    for (int c = 0; c < 5; c++) begin
      @(posedge clk); #1;
      check("R5 fall no strobe", valid_o, 1'b0);
      check("R5 fall dir held", dir_o, held_dir);
    end
    check("R2 rdata low", rdata_o, 1'b0);
  endtask

  initial begin
    #(TCK * 20000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    held_dir = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    check("R1 rdata reset", rdata_o, 1'b0);
    check("R1 dir reset", dir_o, 1'b0);
    check("R1 valid reset", valid_o, 1'b0);
    din = 1'b1;                       // stimulus ignored in reset
    @(posedge clk); #1;
    check("R1 held in reset", valid_o | rdata_o, 1'b0);
    din = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // Sweep the transition across the period, both sides of the falling edge
    for (int i = 0; i < 10; i++) begin
      realtime off;
      off = 0.25 + 0.5 * i;
      rise_trial(off);
      // Falling edge placed on the other side, would flip dir if it counted
      fall_trial((off < TFALL) ? 4.0 : 1.0);
    end

    // R7: back-to-back rises (0,1,0,1), each bit one cycle, late then early
    drive_at(1.0, 1'b0);
    repeat (4) @(posedge clk);
    drive_at(4.0, 1'b1);              // edge k, late
    drive_at(4.0, 1'b0);              // edge k+1
    drive_at(1.0, 1'b1);              // edge k+2, early
    @(posedge clk); #1;               // after k+3
    check("R7 first strobe", valid_o, 1'b1);
    check("R7 first dir late", dir_o, 1'b0);
    @(posedge clk); #1;               // after k+4
    check("R7 gap", valid_o, 1'b0);
    @(posedge clk); #1;               // after k+5
    check("R7 second strobe", valid_o, 1'b1);
    check("R7 second dir early", dir_o, 1'b1);
    @(posedge clk); #1;
    check("R6 single cycle", valid_o, 1'b0);

    // Steady high data: no further strobes
    for (int c = 0; c < 6; c++) begin
      @(posedge clk); #1;
      check("R5 steady no strobe", valid_o, 1'b0);
      check("R5 steady dir held", dir_o, 1'b1);
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule